// File: doc/BRIEF.md
# Processor Trace Capture Filter

This block sits beside a processor and watches two of its buses: the instruction-fetch bus and the data load/store bus. The host sets up the capture. Execution trace and data trace can each be turned on alone or together. The host also picks a data filter mode, and chooses manual or trigger-driven start and stop. Selected cycles become tagged records in a small on-chip circular memory. The host reads that memory back one entry at a time through an address input and a registered data output. The trigger comparators are outside the block; their results arrive as single-cycle start and stop pulses.

Both bus taps carry a valid strobe and no ready. The processor is never stalled, so the block applies no back-pressure. When the block cannot take a record, it drops the record and sets a sticky flag. Only one buffer entry can be written per clock. A one-entry holding register absorbs collisions between the two buses, and it also holds the second entry of records that carry both an address and data.

Every entry is `W+3` bits wide, laid out as follows:
- bits `[W+2:W+1]` hold the kind: `01` instruction, `10` load, `11` store.
- bit `W` holds the continuation flag.
- bits `[W-1:0]` hold the payload.

Top module: `trc_capture`

## Requirements
- R1: While capturing with `cfg_exec_en`=1 and `cfg_single`=0, each cycle with `if_valid`=1 writes one entry at `wr_ptr`. The entry has kind `01`, continuation 0 and payload `if_addr`, and `wr_ptr` then advances by one.
- R2: While capturing with `cfg_data_en`=1, a data cycle produces entries according to `cfg_dmode`:
  - 0: load address
  - 1: store address
  - 2: load or store address
  - 3: load data
  - 4: load address and data
  - 5: store address and data
  - 6: address and data for either
  - 7: nothing

  A load (`d_store`=0) has kind `10`. A store has kind `11`.
- R3: A record carrying both address and data takes two consecutive entries: first the address with continuation 0, then the data with continuation 1. A data-only record is a single entry with continuation 0.
- R4: With `cfg_exec_en`=0, fetch cycles write nothing. With `cfg_data_en`=0, data cycles write nothing.
- R5: If a fetch and a data record are due in the same cycle, the fetch entry is written first and the data record waits in the holding register. It is written on the next free cycle. If the holding register cannot take a new data record, that record is dropped and `st_overflow` is set and stays set.
- R6: With `cfg_trig_mode`=0, `cmd_start` begins capture on the next cycle and `cmd_stop` ends it on the next cycle.
- R7: With `cfg_trig_mode`=1, `cmd_start` sets `st_armed`. A `trig_start` pulse while armed begins capture and clears `st_armed`. A `trig_stop` pulse while capturing ends capture. A `trig_start` pulse while not armed is ignored.
- R8: With `cfg_single`=1, the first data cycle seen while capturing is recorded as address plus data, whatever `cfg_dmode` says. Capture then ends. Fetch cycles are not recorded in this mode.
- R9: With `cfg_stop_full`=1, `st_full` rises when the last entry is written. After that no entry is written, `wr_ptr` holds, and capture ends. The processor is not stalled.
- R10: With `cfg_stop_full`=0, writing continues past the end. The pointer wraps to 0 and the oldest entries are overwritten. `st_wrapped` rises with the first overwrite, not before.
- R11: `rd_data` shows the entry at `rd_addr` one clock after `rd_addr` is applied.
- R12: Reset and `cmd_clear` both do the same thing: they zero `wr_ptr`, clear `st_full`, `st_wrapped`, `st_overflow`, `st_armed` and `st_capturing`, and empty the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch bus cycle strobe |
| if_addr | input | W | Fetch address |
| d_valid | input | 1 | Data bus cycle strobe |
| d_store | input | 1 | 1 for a store, 0 for a load |
| d_addr | input | W | Data bus address |
| d_data | input | W | Data bus data |
| trig_start | input | 1 | Start trigger pulse |
| trig_stop | input | 1 | Stop trigger pulse |
| cfg_exec_en | input | 1 | Enable execution trace |
| cfg_data_en | input | 1 | Enable data trace |
| cfg_dmode | input | 3 | Data filter mode (R2) |
| cfg_single | input | 1 | One-shot data sample mode |
| cfg_trig_mode | input | 1 | 1: triggers start and stop capture |
| cfg_stop_full | input | 1 | Stop when the buffer fills |
| cmd_start | input | 1 | Host start/arm pulse |
| cmd_stop | input | 1 | Host stop pulse |
| cmd_clear | input | 1 | Host clear pulse |
| rd_addr | input | AW | Read index |
| rd_data | output | W+3 | Entry at the read index, registered |
| wr_ptr | output | AW | Next write index |
| st_armed | output | 1 | Waiting for a start trigger |
| st_capturing | output | 1 | Capture active |
| st_full | output | 1 | Buffer filled (sticky) |
| st_wrapped | output | 1 | Oldest entry overwritten (sticky) |
| st_overflow | output | 1 | Data record dropped (sticky) |

## Verification
The assertions check the following on every cycle:
- the pointer only ever holds or steps by one;
- it freezes once a stop-on-full buffer is full;
- wrapping never shows without full;
- armed and capturing are never both set;
- overflow is sticky;
- clear returns everything to zero;
- single-sample mode ends capture after the first data cycle.

Other behaviour can only be shown by the bench's scenarios:
- the entry contents for each filter mode;
- the address-then-data ordering with its continuation bit;
- a fetch winning over a data record that lands later;
- the trigger sequence;
- which entries survive a wrap.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_INSN  = 2'b01,
    K_LOAD  = 2'b10,
    K_STORE = 2'b11
  } kind_e;

  // Returns {want_address, want_data} for one data cycle.
  function automatic logic [1:0] data_wants(input logic [2:0] mode, input logic is_store);
    logic wa, wd;
    wa = 1'b0;
    wd = 1'b0;
    case (mode)
      3'd0: wa = !is_store;
      3'd1: wa = is_store;
      3'd2: wa = 1'b1;
      3'd3: wd = !is_store;
      3'd4: begin wa = !is_store; wd = !is_store; end
      3'd5: begin wa = is_store;  wd = is_store;  end
      3'd6: begin wa = 1'b1;      wd = 1'b1;      end
      default: ;
    endcase
    return {wa, wd};
  endfunction
endpackage

// File: rtl/trc_filter.sv
module trc_filter
  import trc_pkg::*;
(
  input  logic       d_store,
  input  logic [2:0] dmode,
  input  logic       single,
  output logic       want_addr,
  output logic       want_data,
  output kind_e      kind
);
  logic [1:0] w;
  always_comb begin
    w    = data_wants(dmode, d_store);
    kind = d_store ? K_STORE : K_LOAD;
    if (single) begin
      want_addr = 1'b1;
      want_data = 1'b1;
    end else begin
      want_addr = w[1];
      want_data = w[0];
    end
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic trig_mode,
  input  logic trig_start,
  input  logic trig_stop,
  input  logic single,
  input  logic sample_taken,
  input  logic full_stop,
  output logic armed,
  output logic capturing
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      capturing <= 1'b0;
    end else if (clear || cmd_stop || full_stop) begin
      armed     <= 1'b0;
      capturing <= 1'b0;
    end else if (cmd_start) begin
      armed     <= trig_mode;
      capturing <= !trig_mode;
    end else if (armed && trig_start) begin
      armed     <= 1'b0;
      capturing <= 1'b1;
    end else if (capturing && ((trig_mode && trig_stop) || (single && sample_taken))) begin
      capturing <= 1'b0;
    end
  end
endmodule

// File: rtl/trc_writer.sv
module trc_writer
  import trc_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          stop_full,
  input  logic          ins_hit,
  input  logic [W-1:0]  ins_addr,
  input  logic          dat_hit,
  input  kind_e         dat_kind,
  input  logic          dat_wa,
  input  logic          dat_wd,
  input  logic [W-1:0]  dat_addr,
  input  logic [W-1:0]  dat_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W+2:0]  rd_data,
  output logic [AW-1:0] wr_ptr,
  output logic          full,
  output logic          wrapped,
  output logic          overflow
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = W + 3;

  logic [EW-1:0] mem [DEPTH];

  // holding register: pending address / data halves of one data record
  logic          p_na, p_nd, p_ha;
  kind_e         p_kind;
  logic [W-1:0]  p_addr, p_data;

  logic          blocked, p_busy, p_free, sel_pnd, sel_new, we, ovf_evt;
  logic [EW-1:0] wdata;

  always_comb begin
    blocked = stop_full && full;
    p_busy  = p_na || p_nd;
    sel_pnd = !ins_hit && p_busy;
    sel_new = !ins_hit && !p_busy && dat_hit;
    p_free  = !p_busy || (sel_pnd && !(p_na && p_nd));
    we      = (ins_hit || sel_pnd || sel_new) && !blocked;
    ovf_evt = dat_hit && !sel_new && !p_free && !blocked;
    if (ins_hit)      wdata = {K_INSN, 1'b0, ins_addr};
    else if (sel_pnd) wdata = p_na ? {p_kind, 1'b0, p_addr} : {p_kind, p_ha, p_data};
    else              wdata = {dat_kind, 1'b0, dat_wa ? dat_addr : dat_data};
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_na <= 1'b0; p_nd <= 1'b0; p_ha <= 1'b0;
      p_kind <= K_NONE; p_addr <= '0; p_data <= '0;
    end else if (clear || blocked) begin
      p_na <= 1'b0; p_nd <= 1'b0;
    end else begin
      if (sel_pnd) begin
        if (p_na) p_na <= 1'b0;
        else      p_nd <= 1'b0;
      end
      if (sel_new && dat_wa && dat_wd) begin
        p_na <= 1'b0; p_nd <= 1'b1; p_ha <= 1'b1;
        p_kind <= dat_kind; p_data <= dat_data;
      end else if (dat_hit && !sel_new && p_free) begin
        p_na <= dat_wa; p_nd <= dat_wd; p_ha <= dat_wa;
        p_kind <= dat_kind; p_addr <= dat_addr; p_data <= dat_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; full <= 1'b0; wrapped <= 1'b0; overflow <= 1'b0;
    end else if (clear) begin
      wr_ptr <= '0; full <= 1'b0; wrapped <= 1'b0; overflow <= 1'b0;
    end else begin
      if (we) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (wr_ptr == AW'(DEPTH - 1)) full <= 1'b1;
        if (full) wrapped <= 1'b1;
      end
      if (ovf_evt) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_valid,
  input  logic [W-1:0]  if_addr,
  input  logic          d_valid,
  input  logic          d_store,
  input  logic [W-1:0]  d_addr,
  input  logic [W-1:0]  d_data,
  input  logic          trig_start,
  input  logic          trig_stop,
  input  logic          cfg_exec_en,
  input  logic          cfg_data_en,
  input  logic [2:0]    cfg_dmode,
  input  logic          cfg_single,
  input  logic          cfg_trig_mode,
  input  logic          cfg_stop_full,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_clear,
  input  logic [AW-1:0] rd_addr,
  output logic [W+2:0]  rd_data,
  output logic [AW-1:0] wr_ptr,
  output logic          st_armed,
  output logic          st_capturing,
  output logic          st_full,
  output logic          st_wrapped,
  output logic          st_overflow
);
  logic  want_addr, want_data, ins_hit, dat_hit;
  kind_e dkind;

  trc_filter u_flt (
    .d_store  (d_store),
    .dmode    (cfg_dmode),
    .single   (cfg_single),
    .want_addr(want_addr),
    .want_data(want_data),
    .kind     (dkind)
  );

  assign ins_hit = st_capturing && cfg_exec_en && !cfg_single && if_valid;
  assign dat_hit = st_capturing && cfg_data_en && d_valid && (want_addr || want_data);

  trc_ctrl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (cmd_clear),
    .cmd_start   (cmd_start),
    .cmd_stop    (cmd_stop),
    .trig_mode   (cfg_trig_mode),
    .trig_start  (trig_start),
    .trig_stop   (trig_stop),
    .single      (cfg_single),
    .sample_taken(dat_hit),
    .full_stop   (cfg_stop_full && st_full),
    .armed       (st_armed),
    .capturing   (st_capturing)
  );

  trc_writer #(.W(W), .AW(AW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd_clear),
    .stop_full(cfg_stop_full),
    .ins_hit  (ins_hit),
    .ins_addr (if_addr),
    .dat_hit  (dat_hit),
    .dat_kind (dkind),
    .dat_wa   (want_addr),
    .dat_wd   (want_data),
    .dat_addr (d_addr),
    .dat_data (d_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_ptr   (wr_ptr),
    .full     (st_full),
    .wrapped  (st_wrapped),
    .overflow (st_overflow)
  );
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          d_valid,
  input logic          cfg_data_en,
  input logic          cfg_single,
  input logic          cfg_stop_full,
  input logic          cmd_start,
  input logic          cmd_clear,
  input logic [AW-1:0] wr_ptr,
  input logic          st_armed,
  input logic          st_capturing,
  input logic          st_full,
  input logic          st_wrapped,
  input logic          st_overflow
);
  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_clear |=> (wr_ptr == $past(wr_ptr)) || (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overflow && !cmd_clear) |=> st_overflow);

  assert_arm_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_armed && st_capturing));

  assert_single_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_single && st_capturing && d_valid && cfg_data_en && !cmd_start && !cmd_clear)
      |=> !st_capturing);

  assert_full_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop_full && st_full && !cmd_clear) |=> $stable(wr_ptr));

  assert_wrap_after_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_wrapped |-> st_full);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (wr_ptr == '0) && !st_full && !st_wrapped && !st_overflow
                  && !st_armed && !st_capturing);
endmodule

bind trc_capture trc_capture_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .d_valid      (d_valid),
  .cfg_data_en  (cfg_data_en),
  .cfg_single   (cfg_single),
  .cfg_stop_full(cfg_stop_full),
  .cmd_start    (cmd_start),
  .cmd_clear    (cmd_clear),
  .wr_ptr       (wr_ptr),
  .st_armed     (st_armed),
  .st_capturing (st_capturing),
  .st_full      (st_full),
  .st_wrapped   (st_wrapped),
  .st_overflow  (st_overflow)
);

// File: tb/trc_capture_bench.sv
module trc_capture_bench;
  localparam int W  = 32;
  localparam int AW = 4;
  localparam int EW = W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_valid = 0, d_valid = 0, d_store = 0, trig_start = 0, trig_stop = 0;
  logic [W-1:0] if_addr = '0, d_addr = '0, d_data = '0;
  logic cfg_exec_en = 0, cfg_data_en = 0, cfg_single = 0, cfg_trig_mode = 0, cfg_stop_full = 0;
  logic [2:0] cfg_dmode = '0;
  logic cmd_start = 0, cmd_stop = 0, cmd_clear = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [EW-1:0] rd_data;
  logic [AW-1:0] wr_ptr;
  logic st_armed, st_capturing, st_full, st_wrapped, st_overflow;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  trc_capture #(.W(W), .AW(AW)) u_trc_capture (.*);

  // {dmode[2:0], store, expected entries[1:0], first entry is data}
  localparam logic [6:0] VEC [16] = '{
    7'b000_0_01_0, 7'b000_1_00_0, 7'b001_0_00_0, 7'b001_1_01_0,
    7'b010_0_01_0, 7'b010_1_01_0, 7'b011_0_01_1, 7'b011_1_00_0,
    7'b100_0_10_0, 7'b100_1_00_0, 7'b101_0_00_0, 7'b101_1_10_0,
    7'b110_0_10_0, 7'b110_1_10_0, 7'b111_0_00_0, 7'b111_1_00_0
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clear();
    cmd_clear = 1; cyc(); cmd_clear = 0;
  endtask

  task automatic pulse_start();
    cmd_start = 1; cyc(); cmd_start = 0;
  endtask

  task automatic pulse_stop();
    cmd_stop = 1; cyc(); cmd_stop = 0;
  endtask

  task automatic rd(input int a, output logic [EW-1:0] e);
    rd_addr = AW'(a); cyc(); e = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [EW-1:0] e;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R12 reset state
    chk("R12 reset status",
        {wr_ptr, st_armed, st_capturing, st_full, st_wrapped, st_overflow}, '0);

    // R2/R3 table: data filter modes
    for (int i = 0; i < 16; i++) begin
      logic [6:0] v;
      v = VEC[i];
      pulse_clear();
      cfg_exec_en = 0; cfg_data_en = 1; cfg_dmode = v[6:4];
      pulse_start();
      d_valid = 1; d_store = v[3];
      d_addr = 32'hA000 + i; d_data = 32'hD000 + i;
      cyc();
      d_valid = 0;
      cyc();
      pulse_stop();
      chk($sformatf("R2 mode %0d store %0d count", v[6:4], v[3]), wr_ptr, v[2:1]);
      if (v[2:1] != 0) begin
        rd(0, e);
        chk("R2 kind", e[EW-1:EW-2], v[3] ? 2'b11 : 2'b10);
        chk("R3 first entry", e[W:0], {1'b0, v[0] ? d_data : d_addr});
      end
      if (v[2:1] == 2) begin
        rd(1, e);
        chk("R3 second entry", e[W:0], {1'b1, d_data});
      end
    end

    // R1/R6/R11 execution trace, manual stop
    pulse_clear();
    cfg_exec_en = 1; cfg_data_en = 0;
    pulse_start();
    chk("R6 start", st_capturing, 1);
    for (int k = 0; k < 3; k++) begin
      if_valid = 1; if_addr = 32'h100 + 4 * k; cyc();
    end
    if_valid = 0;
    pulse_stop();
    chk("R6 stop", st_capturing, 0);
    if_valid = 1; cyc(); if_valid = 0; cyc();
    chk("R1 R6 count", wr_ptr, 3);
    for (int k = 0; k < 3; k++) begin
      rd(k, e);
      chk("R1 R11 entry", e, {2'b01, 1'b0, 32'h100 + 4 * k});
    end

    // R4 enables
    pulse_clear();
    cfg_exec_en = 1; cfg_data_en = 0; cfg_dmode = 3'd6;
    pulse_start();
    d_valid = 1; cyc(); cyc(); d_valid = 0; cyc();
    chk("R4 data disabled", wr_ptr, 0);
    cfg_exec_en = 0; cfg_data_en = 1; cfg_dmode = 3'd2;
    if_valid = 1; cyc(); cyc(); if_valid = 0; cyc();
    chk("R4 exec disabled", wr_ptr, 0);
    pulse_stop();

    // R5 collision and overflow
    pulse_clear();
    cfg_exec_en = 1; cfg_data_en = 1; cfg_dmode = 3'd2;
    pulse_start();
    if_valid = 1; if_addr = 32'h500; d_valid = 1; d_store = 0; d_addr = 32'hAA; cyc();
    chk("R5 no overflow yet", st_overflow, 0);
    if_addr = 32'h504; d_addr = 32'hBB; cyc();
    if_valid = 0; d_valid = 0; cyc(); cyc();
    pulse_stop();
    chk("R5 overflow", st_overflow, 1);
    chk("R5 count", wr_ptr, 3);
    rd(0, e); chk("R5 fetch first", e, {2'b01, 1'b0, 32'h500});
    rd(2, e); chk("R5 held record", e, {2'b10, 1'b0, 32'hAA});

    // R7 trigger control
    pulse_clear();
    cfg_trig_mode = 1; cfg_exec_en = 1; cfg_data_en = 0;
    trig_start = 1; if_valid = 1; cyc(); trig_start = 0; cyc(); if_valid = 0;
    chk("R7 trigger ignored unarmed", {st_capturing, wr_ptr}, 0);
    pulse_start();
    chk("R7 armed", {st_armed, st_capturing}, 2'b10);
    trig_start = 1; if_valid = 1; if_addr = 32'h700; cyc(); trig_start = 0;
    chk("R7 triggered", {st_armed, st_capturing}, 2'b01);
    if_addr = 32'h704; cyc();
    if_addr = 32'h708; trig_stop = 1; cyc(); trig_stop = 0;
    if_addr = 32'h70C; cyc(); if_valid = 0;
    chk("R7 stopped", st_capturing, 0);
    chk("R7 count", wr_ptr, 2);
    rd(0, e); chk("R7 entry0", e[W-1:0], 32'h704);
    rd(1, e); chk("R7 entry1", e[W-1:0], 32'h708);

    // R8 single sample
    pulse_clear();
    cfg_single = 1; cfg_data_en = 1; cfg_exec_en = 1; cfg_dmode = 3'd0;
    pulse_start();
    trig_start = 1; cyc(); trig_start = 0;
    if_valid = 1; d_valid = 1; d_store = 1; d_addr = 32'h5A; d_data = 32'h5D;
    cyc();
    d_addr = 32'h6A; cyc(); cyc();
    if_valid = 0; d_valid = 0; cyc();
    chk("R8 capture ended", st_capturing, 0);
    chk("R8 count", wr_ptr, 2);
    rd(0, e); chk("R8 address", e, {2'b11, 1'b0, 32'h5A});
    rd(1, e); chk("R8 data", e, {2'b11, 1'b1, 32'h5D});
    cfg_single = 0; cfg_trig_mode = 0;

    // R9 stop on full
    pulse_clear();
    cfg_stop_full = 1; cfg_exec_en = 1; cfg_data_en = 0;
    pulse_start();
    for (int k = 0; k < 20; k++) begin
      if_valid = 1; if_addr = 32'h1000 + 4 * k; cyc();
    end
    if_valid = 0; cyc();
    chk("R9 full", {st_full, st_wrapped, st_capturing}, 3'b100);
    chk("R9 pointer held", wr_ptr, 0);
    rd(0, e); chk("R9 oldest kept", e[W-1:0], 32'h1000);

    // R10 wrap
    pulse_clear();
    cfg_stop_full = 0;
    pulse_start();
    for (int k = 0; k < 16; k++) begin
      if_valid = 1; if_addr = 32'h2000 + 4 * k; cyc();
    end
    if_valid = 0;
    chk("R10 full not wrapped", {st_full, st_wrapped, wr_ptr}, {2'b10, 4'd0});
    for (int k = 16; k < 18; k++) begin
      if_valid = 1; if_addr = 32'h2000 + 4 * k; cyc();
    end
    if_valid = 0;
    pulse_stop();
    chk("R10 wrapped", {st_wrapped, wr_ptr}, {1'b1, 4'd2});
    rd(0, e); chk("R10 overwritten", e[W-1:0], 32'h2040);
    rd(2, e); chk("R10 survivor", e[W-1:0], 32'h2008);

    // R12 clear
    pulse_clear();
    chk("R12 clear",
        {wr_ptr, st_armed, st_capturing, st_full, st_wrapped, st_overflow}, '0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule